// File: doc/BRIEF.md
# Array Write Protection Controller

This block sits beside the byte-array write path of a two-wire serial memory. On every cycle it decides whether a write to the presented byte address may go ahead. The decision combines a hardware write-protect pin with two protection flags. The reversible flag can be set and cleared again. The permanent flag, once set, stays set until reset. Either flag, when set, locks only the lower half of the array.

The bus front end decodes each device-address byte and hands it to the block with a one-cycle strobe. Bytes that carry the protection prefix `0110` are commands to this block. They are accepted only while the A0 select pin is driven to the high-voltage level. The reply, acknowledge or no-acknowledge, appears one cycle after the strobe, and that reply encodes the state of the flag. A write that protection blocks is still acknowledged on the bus, but it never produces an internal write-cycle start.

Top module: `wprot_ctrl`

## Requirements
- R1: After reset both flags are 0. `rsp_valid` is 0, and with `wp_pin` low every address, including 00h to 7Fh, gives `wr_allow` = 1.
- R2: While `wp_pin` is 1, `wr_allow` is 0 for every address, and every protection command is answered with no-acknowledge and changes no flag.
- R3: While `wp_pin` is 0, addresses with the top address bit set (80h to FFh) always give `wr_allow` = 1, whatever the flags hold.
- R4: While `wp_pin` is 0, addresses 00h to 7Fh give `wr_allow` = 1 only when both flags are 0.
- R5: `wr_start` pulses only for a requested write that is allowed. A blocked request leaves `wr_start` at 0.
- R6: A strobed byte whose bits 7:4 are `0110` produces `rsp_valid` = 1 in the following cycle. Any other byte produces no response and changes no flag.
- R7: A protection command is eligible only if all of these hold: `a0_hv` is 1, `wp_pin` is 0, byte bit 1 is 1, and byte bits 3:1 equal `sel_pins` (bit 3 for A2, bit 2 for A1, bit 1 for A0). An ineligible command is answered with no-acknowledge and changes no flag.
- R8: Byte `0110_0110` (A2=0, A1=1, write direction) sets the reversible flag, and byte `0110_0010` (A1=0) clears it. Both are acknowledged when the permanent flag is 0.
- R9: A reversible-flag read (bits 3:2 = `00`, bit 0 = 1) is acknowledged when that flag is 0 and not acknowledged when it is 1. It changes no flag.
- R10: Byte `0110_1010` (A2=1, A1=0, write direction) sets the permanent flag and is acknowledged when that flag was 0. If the flag is already 1 the command is not acknowledged. No command ever clears the permanent flag.
- R11: While the permanent flag is 1, a set or clear of the reversible flag is answered with no-acknowledge and leaves that flag unchanged.
- R12: A permanent-flag read (byte `0110_1011`) is acknowledged when that flag is 0 and not acknowledged when it is 1. Any other eligible select code (A2=1 with A1=1) is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, clears both flags |
| wp_pin | input | 1 | Hardware write-protect level |
| a0_hv | input | 1 | High-voltage level present on the A0 select pin |
| sel_pins | input | 3 | Logic levels of select pins A2, A1, A0 |
| cmd_strobe | input | 1 | One-cycle strobe for a decoded device-address byte |
| cmd_byte | input | 8 | Device-address byte, bit 0 is the direction (1 = read) |
| wr_addr | input | AW | Byte address of the pending write |
| wr_req | input | 1 | Request to start an internal write cycle |
| wr_allow | output | 1 | The write to `wr_addr` is permitted |
| wr_start | output | 1 | Internal write-cycle start |
| rsp_valid | output | 1 | A protection-command reply is present |
| rsp_ack | output | 1 | Reply: 1 = acknowledge, 0 = no-acknowledge |

## Verification
The bound checker verifies the following on every cycle: the hardware pin overrides everything, the upper half always stays writable while that pin is low, a write start never touches a locked address, a reply follows only a protection-prefix strobe, the permanent flag never falls, and the reversible flag is frozen while the permanent flag is set. Some behaviour only the bench's scenarios can show. This covers the exact reply for each command against the current flag state, the rejection of commands with missing high voltage or mismatched select pins, and the way the flags stay in effect across a sequence of commands and are released by reset.

// File: rtl/wprot_ctrl.sv
module wprot_ctrl #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wp_pin,
  input  logic          a0_hv,
  input  logic [2:0]    sel_pins,
  input  logic          cmd_strobe,
  input  logic [7:0]    cmd_byte,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_req,
  output logic          wr_allow,
  output logic          wr_start,
  output logic          rsp_valid,
  output logic          rsp_ack
);
  localparam logic [3:0] PROT_PREFIX = 4'b0110;
  localparam logic [1:0] OP_REV      = 2'b00;
  localparam logic [1:0] OP_PERM     = 2'b10;

  logic rev_q, perm_q;
  logic rev_d, perm_d, ack_d;

  wire is_prot  = cmd_strobe && (cmd_byte[7:4] == PROT_PREFIX);
  wire eligible = a0_hv && !wp_pin && cmd_byte[1] && (cmd_byte[3:1] == sel_pins);
  wire dir_rd   = cmd_byte[0];

  always_comb begin
    rev_d  = rev_q;
    perm_d = perm_q;
    ack_d  = 1'b0;
    if (is_prot && eligible) begin
      if (cmd_byte[3:2] == OP_REV || cmd_byte[3:2] == 2'b01) begin
        if (cmd_byte[3] == 1'b0) begin
          if (dir_rd) begin
            ack_d = !rev_q;
          end else if (!perm_q) begin
            rev_d = cmd_byte[2];
            ack_d = 1'b1;
          end
        end
      end else if (cmd_byte[3:2] == OP_PERM) begin
        if (dir_rd) begin
          ack_d = !perm_q;
        end else if (!perm_q) begin
          perm_d = 1'b1;
          ack_d  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rev_q     <= 1'b0;
      perm_q    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_ack   <= 1'b0;
    end else begin
      rev_q     <= rev_d;
      perm_q    <= perm_d;
      rsp_valid <= is_prot;
      rsp_ack   <= ack_d;
    end
  end

  assign wr_allow = !wp_pin && (wr_addr[AW-1] || !(rev_q || perm_q));
  assign wr_start = wr_req && wr_allow;
endmodule

// File: rtl/wprot_ctrl_chk.sv
module wprot_ctrl_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wp_pin,
  input logic          cmd_strobe,
  input logic [7:0]    cmd_byte,
  input logic [AW-1:0] wr_addr,
  input logic          wr_allow,
  input logic          wr_start,
  input logic          rsp_valid,
  input logic          rev_q,
  input logic          perm_q
);
  assert_pin_locks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wp_pin |-> !wr_allow && !wr_start);

  assert_upper_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_pin && wr_addr[AW-1]) |-> wr_allow);

  assert_start_safe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> (wr_addr[AW-1] || (!rev_q && !perm_q)));

  assert_reply_prefix_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cmd_strobe && cmd_byte[7:4] == 4'b0110));

  assert_perm_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(perm_q) |-> perm_q);

  assert_rev_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(perm_q) && perm_q) |-> $stable(rev_q));
endmodule

bind wprot_ctrl wprot_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin), .cmd_strobe(cmd_strobe),
  .cmd_byte(cmd_byte), .wr_addr(wr_addr), .wr_allow(wr_allow),
  .wr_start(wr_start), .rsp_valid(rsp_valid), .rev_q(rev_q), .perm_q(perm_q)
);

// File: tb/wprot_ctrl_bench.sv
module wprot_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wp_pin = 1'b0, a0_hv = 1'b0, cmd_strobe = 1'b0, wr_req = 1'b0;
  logic [2:0] sel_pins = 3'b000;
  logic [7:0] cmd_byte = 8'h00, wr_addr = 8'h00;
  logic       wr_allow, wr_start, rsp_valid, rsp_ack;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  wprot_ctrl #(.AW(8)) u_wprot_ctrl (
    .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin), .a0_hv(a0_hv), .sel_pins(sel_pins),
    .cmd_strobe(cmd_strobe), .cmd_byte(cmd_byte), .wr_addr(wr_addr), .wr_req(wr_req),
    .wr_allow(wr_allow), .wr_start(wr_start), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack)
  );

  // {wp, hv, sel[2:0], cmd[7:0], exp_valid, exp_ack, exp_lower_allow}
  localparam int NV = 15;
  localparam logic [15:0] VEC [NV] = '{
    16'b0_1_001_10100010_0_0_1,
    16'b0_1_011_01100110_1_1_0,
    16'b0_1_011_01100111_1_0_0,
    16'b0_0_001_01100010_1_0_0,
    16'b0_1_011_01100010_1_0_0,
    16'b1_1_001_01100010_1_0_0,
    16'b0_1_001_01100010_1_1_1,
    16'b0_1_001_01100011_1_1_1,
    16'b0_1_101_01101011_1_1_1,
    16'b0_1_101_01101010_1_1_0,
    16'b0_1_101_01101010_1_0_0,
    16'b0_1_101_01101011_1_0_0,
    16'b0_1_011_01100110_1_0_0,
    16'b0_1_001_01100011_1_1_0,
    16'b0_1_111_01101111_1_0_0
  };

  function automatic string vec_tag(int i);
    case (i)
      0: return "R6 foreign prefix";
      1: return "R8 set reversible";
      2: return "R9 read reversible set";
      3: return "R7 no high voltage";
      4: return "R7 select mismatch";
      5: return "R2 pin blocks command";
      6: return "R8 clear reversible";
      7: return "R9 read reversible clear";
      8: return "R12 read permanent clear";
      9: return "R10 set permanent";
      10: return "R10 permanent already set";
      11: return "R12 read permanent set";
      12: return "R11 set reversible under permanent";
      13: return "R11 reversible unchanged";
      default: return "R12 unknown select code";
    endcase
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic send(logic wp, logic hv, logic [2:0] sel, logic [7:0] b);
    @(negedge clk);
    wp_pin = wp; a0_hv = hv; sel_pins = sel; cmd_byte = b; cmd_strobe = 1'b1;
    @(negedge clk);
    cmd_strobe = 1'b0; wp_pin = 1'b0; a0_hv = 1'b0;
  endtask

  initial begin
    #500us;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 no reply after reset", rsp_valid, 1'b0);
    wr_addr = 8'h00; #1 chk("R1 address 00h open", wr_allow, 1'b1);
    wr_addr = 8'h7F; #1 chk("R4 address 7Fh open with flags clear", wr_allow, 1'b1);
    wp_pin = 1'b1; wr_addr = 8'hFF; #1 chk("R2 pin locks FFh", wr_allow, 1'b0);
    wp_pin = 1'b0; wr_addr = 8'h80; wr_req = 1'b1;
    #1 chk("R5 allowed request starts", wr_start, 1'b1);
    wr_req = 1'b0;

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][15], VEC[i][14], VEC[i][13:11], VEC[i][10:3]);
      chk({vec_tag(i), " valid"}, rsp_valid, VEC[i][2]);
      if (VEC[i][2]) chk({vec_tag(i), " ack"}, rsp_ack, VEC[i][1]);
      wr_addr = 8'h10;
      #1 chk({vec_tag(i), " R4 lower allow"}, wr_allow, VEC[i][0]);
    end

    wr_addr = 8'h00; wr_req = 1'b1;
    #1 chk("R5 blocked request no start", wr_start, 1'b0);
    wr_addr = 8'hC0;
    #1 chk("R3 upper open with flags set", wr_allow, 1'b1);
    chk("R5 upper request starts", wr_start, 1'b1);
    wp_pin = 1'b1;
    #1 chk("R2 pin locks upper half", wr_allow, 1'b0);
    wp_pin = 1'b0; wr_req = 1'b0;

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    wr_addr = 8'h00;
    #1 chk("R1 reset releases lower half", wr_allow, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule